// File: doc/BRIEF.md
# Paged-Interrupt 48-Line GPIO Controller

This controller gives a byte-wide host bus access to 48 general-purpose lines, arranged as six 8-bit ports, through a 16-byte address window. Each port has an output latch that drives its lines open-drain. A port read returns the synchronized level on the pins.

The 24 lines of the first three ports can raise edge-triggered interrupts. Three byte offsets above the summary and page registers are shared by three banks: interrupt enables, edge polarity, and the pending-flag identification bank. The value last written to the page register picks which bank those offsets reach.

A handler reads the summary register to find which of the three ports need service, selects the identification bank, and reads that port's pending bits. It acknowledges a line by writing the enable byte with that bit cleared and then writing it again with the bit set. The single active-high interrupt request stays high while any pending flag is set. Reads have no side effects: the read data follows the address combinationally, and a write takes effect on the clock edge where the write strobe is high.

Top module: `gpio48_paged_irq`

## Requirements
- R1: A write to offset p (0 to 5) loads port p's output latch. A latch bit of 1 drives line 8p+b low (`pinDriveLow[8p+b]`=1), and a latch bit of 0 releases the line. The change is visible after the clock edge of the write.
- R2: A read of offset p (0 to 5) returns the pin levels `pinIn[8p+7:8p]` after a two-flop synchronizer. A pin change made between edges is not seen after one rising edge and is seen after the second.
- R3: Offset 7 is the page register and reads back the value last written to it. The page value selects what offsets 8 to 10 reach: 0x80 selects the enable bank, 0x40 the polarity bank, and 0xC0 the identification bank. Under any other page value, offsets 8 to 10 read zero and ignore writes.
- R4: In the enable bank, a write to offset 8+p (p = 0 to 2) sets the enable byte of port p, and a read returns that byte.
- R5: In the polarity bank, a 1 at bit b of offset 8+p selects a rising edge for line 8p+b, and a 0 selects a falling edge. A pending flag is set only on the selected edge, and only while the line's enable bit is 1.
- R6: In the identification bank, a read of offset 8+p returns port p's pending flags, with bit b for line 8p+b. Writes to this bank change nothing.
- R7: Offset 6 is read-only. Bit p (p = 0 to 2) is 1 when port p has any pending flag, and bits 7 to 3 read 0.
- R8: While a line's enable bit is 0, its pending flag is held clear. Writing the enable byte with a bit cleared and then with the bit set acknowledges the line and re-arms it, and other lines keep their flags. Writing zero to all three enable bytes leaves no flag pending.
- R9: Lines of ports 3 to 5 never set a pending flag, raise the request, or change the summary.
- R10: `irq` is active-high and is 1 exactly while at least one pending flag is set.
- R11: Offsets 11 to 15 read as zero, and writes to them change no state.
- R12: After reset, all latches, enables, polarities and pending flags are 0, `irq` is 0, and the page register reads 0xC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte offset in the register window |
| wrStb | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| pinIn | input | 48 | Sensed pin levels |
| pinDriveLow | output | 48 | 1 pulls the line low, 0 releases it |
| irq | output | 1 | Interrupt request, active-high |

## Verification
A corrupted enable or polarity byte shows up as a missing or extra pending flag. It becomes visible in the identification bank, the summary and `irq` three rising edges after the pin edge that exposes it, and a direct readback of the bank shows it at once. A wrong bank decode for a page value shows on the very next read of offsets 8 to 10. The acknowledge sequence is checked so that a flag left set after the cleared-then-set write pair, or a neighbouring line's flag lost by it, shows on the next identification read. A stage missing from the synchronizer shows as a port read that changes one edge early.

// File: rtl/gpio48_pkg.sv
package gpio48_pkg;
  parameter int NUM_PORTS = 6;
  parameter int PORT_W    = 8;
  parameter int IRQ_PORTS = 3;
  parameter int ADDR_W    = 4;

  localparam int NUM_PINS = NUM_PORTS * PORT_W;
  localparam int IRQ_PINS = IRQ_PORTS * PORT_W;
  localparam int IDX_W    = $clog2(NUM_PORTS);
  localparam int SUM_OFS  = NUM_PORTS;
  localparam int PAGE_OFS = NUM_PORTS + 1;
  localparam int BANK_OFS = NUM_PORTS + 2;
  localparam int RES_OFS  = BANK_OFS + IRQ_PORTS;

  localparam logic [PORT_W-1:0] PAGE_EN  = 8'h80;
  localparam logic [PORT_W-1:0] PAGE_POL = 8'h40;
  localparam logic [PORT_W-1:0] PAGE_ID  = 8'hC0;

  typedef enum logic [2:0] {
    RD_ZERO, RD_PIN, RD_SUM, RD_PAGE, RD_EN, RD_POL, RD_ID
  } rd_sel_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0] portWr;
    logic [IRQ_PORTS-1:0] enWr;
    logic [IRQ_PORTS-1:0] polWr;
    rd_sel_e              rdSel;
    logic [IDX_W-1:0]     rdIdx;
  } gpio_strb_t;
endpackage

// File: rtl/gpio48_ctrl.sv
module gpio48_ctrl
  import gpio48_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrStb,
  input  logic [PORT_W-1:0] wrData,
  output gpio_strb_t        strb,
  output logic [PORT_W-1:0] pageQ
);
  typedef enum logic [1:0] {BANK_NONE, BANK_EN, BANK_POL, BANK_ID} bank_e;

  bank_e bank;
  int    addrInt;

  assign addrInt = int'(addr);

  always_ff @(posedge clk) begin
    if (!rstN) pageQ <= PAGE_ID;
    else if (wrStb && addrInt == PAGE_OFS) pageQ <= wrData;
  end

  always_comb begin
    case (pageQ)
      PAGE_EN:  bank = BANK_EN;
      PAGE_POL: bank = BANK_POL;
      PAGE_ID:  bank = BANK_ID;
      default:  bank = BANK_NONE;
    endcase
  end

  always_comb begin
    strb.portWr = '0;
    strb.enWr   = '0;
    strb.polWr  = '0;
    strb.rdSel  = RD_ZERO;
    strb.rdIdx  = '0;
    if (addrInt < NUM_PORTS) begin
      strb.rdSel = RD_PIN;
      strb.rdIdx = IDX_W'(addrInt);
      for (int i = 0; i < NUM_PORTS; i++)
        if (addrInt == i) strb.portWr[i] = wrStb;
    end else if (addrInt == SUM_OFS) begin
      strb.rdSel = RD_SUM;
    end else if (addrInt == PAGE_OFS) begin
      strb.rdSel = RD_PAGE;
    end else if (addrInt < RES_OFS) begin
      strb.rdIdx = IDX_W'(addrInt - BANK_OFS);
      case (bank)
        BANK_EN:  strb.rdSel = RD_EN;
        BANK_POL: strb.rdSel = RD_POL;
        BANK_ID:  strb.rdSel = RD_ID;
        default:  strb.rdSel = RD_ZERO;
      endcase
      for (int i = 0; i < IRQ_PORTS; i++) begin
        if (addrInt == BANK_OFS + i) begin
          strb.enWr[i]  = wrStb && (bank == BANK_EN);
          strb.polWr[i] = wrStb && (bank == BANK_POL);
        end
      end
    end
  end
endmodule

// File: rtl/gpio48_dpath.sv
module gpio48_dpath
  import gpio48_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  gpio_strb_t          strb,
  input  logic [PORT_W-1:0]   wrData,
  input  logic [PORT_W-1:0]   pageQ,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinDriveLow,
  output logic [IRQ_PINS-1:0] enVec,
  output logic [IRQ_PINS-1:0] pendVec,
  output logic [PORT_W-1:0]   rdData
);
  logic [NUM_PINS-1:0]  latchQ, syncA, syncB;
  logic [IRQ_PINS-1:0]  prevQ, polVec, edgeHit;
  logic [IRQ_PORTS-1:0] sumVec;
  int                   selBase;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) latchQ[p*PORT_W +: PORT_W] <= '0;
      else if (strb.portWr[p]) latchQ[p*PORT_W +: PORT_W] <= wrData;
    end
  end

  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rstN) begin
        enVec[p*PORT_W +: PORT_W]  <= '0;
        polVec[p*PORT_W +: PORT_W] <= '0;
      end else begin
        if (strb.enWr[p])  enVec[p*PORT_W +: PORT_W]  <= wrData;
        if (strb.polWr[p]) polVec[p*PORT_W +: PORT_W] <= wrData;
      end
    end
    assign sumVec[p] = |pendVec[p*PORT_W +: PORT_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevQ   <= '0;
      pendVec <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevQ   <= syncB[IRQ_PINS-1:0];
      pendVec <= (pendVec | (edgeHit & enVec)) & enVec;
    end
  end

  assign edgeHit = (syncB[IRQ_PINS-1:0] & ~prevQ & polVec)
                 | (~syncB[IRQ_PINS-1:0] & prevQ & ~polVec);

  assign pinDriveLow = latchQ;
  assign selBase     = int'(strb.rdIdx) * PORT_W;

  always_comb begin
    case (strb.rdSel)
      RD_PIN:  rdData = syncB[selBase +: PORT_W];
      RD_SUM:  rdData = PORT_W'(sumVec);
      RD_PAGE: rdData = pageQ;
      RD_EN:   rdData = enVec[selBase +: PORT_W];
      RD_POL:  rdData = polVec[selBase +: PORT_W];
      RD_ID:   rdData = pendVec[selBase +: PORT_W];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio48_paged_irq.sv
module gpio48_paged_irq
  import gpio48_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrStb,
  input  logic [PORT_W-1:0]   wrData,
  output logic [PORT_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinDriveLow,
  output logic                irq
);
  gpio_strb_t          strb;
  logic [PORT_W-1:0]   pageQ;
  logic [IRQ_PINS-1:0] enVec, pendVec;

  gpio48_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrStb(wrStb), .wrData(wrData),
    .strb(strb), .pageQ(pageQ)
  );

  gpio48_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .pageQ(pageQ),
    .pinIn(pinIn), .pinDriveLow(pinDriveLow), .enVec(enVec),
    .pendVec(pendVec), .rdData(rdData)
  );

  assign irq = |pendVec;
endmodule

// File: rtl/gpio48_chk.sv
module gpio48_chk
  import gpio48_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                wrStb,
  input logic [PORT_W-1:0]   wrData,
  input logic [PORT_W-1:0]   rdData,
  input logic [NUM_PINS-1:0] pinDriveLow,
  input logic                irq,
  input logic [IRQ_PINS-1:0] enVec,
  input logic [IRQ_PINS-1:0] pendVec
);
  // R1
  port_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && int'(addr) < NUM_PORTS) |=>
      pinDriveLow[int'($past(addr))*PORT_W +: PORT_W] == $past(wrData));

  // R11
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && int'(addr) >= RES_OFS) |=> ($stable(pinDriveLow) && $stable(enVec)));

  // R11
  reserved_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(addr) >= RES_OFS) |-> rdData == '0);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pendVec & ~$past(enVec)) == '0);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(enVec) != '0);

  // R7
  summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(addr) == SUM_OFS) |-> (rdData[PORT_W-1:IRQ_PORTS] == '0 && ((rdData != '0) == irq)));
endmodule

bind gpio48_paged_irq gpio48_chk chk (.*);

// File: tb/gpio48_paged_irq_test.sv
module gpio48_paged_irq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrStb = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [47:0] pinIn = '0;
  logic [47:0] pinDriveLow;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] latchModel [6];

  always #2 clk = ~clk;

  gpio48_paged_irq uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrStb(wrStb), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinDriveLow(pinDriveLow), .irq(irq)
  );

  function automatic logic [47:0] expDrive();
    logic [47:0] v;
    for (int p = 0; p < 6; p++) v[p*8 +: 8] = latchModel[p];
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int p = 0; p < 6; p++) latchModel[p] = '0;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R12 reset state
    chk("R12 drive", pinDriveLow, 48'h0);
    chk("R12 irq", irq, 0);
    rdChk("R12 page", 4'd7, 8'hC0);
    rdChk("R12 summary", 4'd6, 8'h00);
    rdChk("R12 id0", 4'd8, 8'h00);

    // R1 random port writes
    for (int i = 0; i < 30; i++) begin
      int p;
      logic [7:0] d;
      p = int'($urandom_range(5, 0));
      d = 8'($urandom);
      wr(4'(p), d);
      latchModel[p] = d;
      chk("R1 latch", pinDriveLow, expDrive());
    end

    // R2 synchronizer latency
    pinIn[23:16] = 8'hA5;
    @(negedge clk);
    rdChk("R2 one edge", 4'd2, 8'h00);
    @(negedge clk);
    rdChk("R2 two edges", 4'd2, 8'hA5);

    // R2 random pin patterns
    for (int i = 0; i < 8; i++) begin
      logic [47:0] v;
      v = {16'($urandom), 32'($urandom)};
      pinIn = v;
      tick(3);
      for (int p = 0; p < 6; p++) rdChk("R2 pins", 4'(p), v[p*8 +: 8]);
    end
    pinIn = '0;
    tick(4);
    chk("R5 no enable no irq", irq, 0);

    // R3 / R4 bank programming
    wr(4'd7, 8'h80);
    rdChk("R3 page readback", 4'd7, 8'h80);
    wr(4'd8, 8'h0F); wr(4'd9, 8'hF0); wr(4'd10, 8'h81);
    rdChk("R4 en0", 4'd8, 8'h0F);
    rdChk("R4 en1", 4'd9, 8'hF0);
    rdChk("R4 en2", 4'd10, 8'h81);
    wr(4'd7, 8'h40);
    wr(4'd8, 8'hFF); wr(4'd9, 8'h00); wr(4'd10, 8'h01);
    rdChk("R3 pol0", 4'd8, 8'hFF);
    rdChk("R3 pol2", 4'd10, 8'h01);
    wr(4'd7, 8'h80);
    rdChk("R3 en kept", 4'd8, 8'h0F);
    wr(4'd7, 8'h12);
    rdChk("R3 unmapped read", 4'd8, 8'h00);
    wr(4'd8, 8'hAA);
    wr(4'd7, 8'h80);
    rdChk("R3 unmapped write", 4'd8, 8'h0F);
    chk("R10 idle", irq, 0);

    // R5 / R6 / R7 / R10 edges
    wr(4'd7, 8'hC0);
    pinIn[0] = 1'b1; tick(4);
    chk("R10 irq set", irq, 1);
    rdChk("R7 sum p0", 4'd6, 8'h01);
    rdChk("R6 id0", 4'd8, 8'h01);
    pinIn[4] = 1'b1; tick(4);
    rdChk("R5 disabled line", 4'd8, 8'h01);
    pinIn[12] = 1'b1; tick(4);
    rdChk("R5 wrong edge", 4'd9, 8'h00);
    pinIn[12] = 1'b0; tick(4);
    rdChk("R5 falling edge", 4'd9, 8'h10);
    rdChk("R7 sum p0p1", 4'd6, 8'h03);
    pinIn[23] = 1'b1; tick(4);
    rdChk("R5 p2 rise ignored", 4'd10, 8'h00);
    pinIn[16] = 1'b1; pinIn[23] = 1'b0; tick(4);
    rdChk("R5 p2 mixed", 4'd10, 8'h81);
    rdChk("R7 sum all", 4'd6, 8'h07);
    wr(4'd8, 8'h00);
    rdChk("R6 id write ignored", 4'd8, 8'h01);

    // R8 acknowledge
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h0E); wr(4'd8, 8'h0F);
    wr(4'd7, 8'hC0);
    rdChk("R8 ack cleared", 4'd8, 8'h00);
    rdChk("R8 other kept", 4'd9, 8'h10);
    rdChk("R8 sum", 4'd6, 8'h06);
    pinIn[0] = 1'b0; tick(4);
    pinIn[0] = 1'b1; tick(4);
    rdChk("R8 rearmed", 4'd8, 8'h01);

    // R8 clear all enables
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00);
    tick(1);
    chk("R8 R10 all off", irq, 0);
    rdChk("R8 sum zero", 4'd6, 8'h00);

    // R9 upper ports cannot interrupt
    wr(4'd8, 8'hFF); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      pinIn[47:24] = 24'($urandom);
      tick(4);
      chk("R9 irq", irq, 0);
      rdChk("R9 sum", 4'd6, 8'h00);
    end

    // R11 reserved offsets
    for (int a = 11; a < 16; a++) rdChk("R11 read", 4'(a), 8'h00);
    for (int a = 11; a < 16; a++) wr(4'(a), 8'hFF);
    chk("R11 latches", pinDriveLow, expDrive());
    rdChk("R11 enables", 4'd8, 8'hFF);
    rdChk("R11 page", 4'd7, 8'h80);
    chk("R11 irq", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule